// File: doc/BRIEF.md
# Serial Video Word Aligner with Timing-Reference Search

This block takes a recovered serial bit stream, one bit per strobe, and packs it into 20-bit parallel words. Each word carries two interleaved 10-bit video samples: the lower half holds one sample and the upper half holds the other. The bit received first lands in bit 0. At power-up the packing boundary is arbitrary. The block therefore searches the word stream for the four-word timing reference that opens and closes the active part of every video line. That reference is a word of all ones, two words of all zeros, and then a flag word.

If a full line period passes without a reference, the block moves the word boundary one bit later and starts the search again. It repeats this until it finds a reference, then raises a locked flag. While locked it marks every end-of-active-video reference with a line pulse, and it marks the start of each new frame with a frame pulse.

The serial input has only a valid strobe and cannot be back-pressured. The word output is also a bare valid strobe with no ready. A downstream consumer must accept every word in the single cycle its strobe is high. The word stays on the bus, unchanged, until the next strobe. The line timeout is a parameter counted in words (`TIMEOUT_WORDS`, default 2200).

Top module: `sync_word_aligner`

## Requirements
- R1: After reset is released, `word_vld`, `locked`, `line_pulse` and `frame_pulse` are low and `word_o` is zero.
- R2: A word completes every 20 accepted bit strobes while no slip is pending. The first bit of the word goes to bit 0. `word_vld` is high for one cycle, one clock after the completing bit strobe. `word_o` changes only in that cycle.
- R3: A reference is four consecutive words: 20'hFFFFF, zero, zero, then a flag word. In the flag word both 10-bit halves are equal and bit 9 of each half is 1. Within each half, bit 8 is the field flag F and bit 6 is the H flag (H=1 marks end of active video, H=0 marks start). A fourth word with unequal halves or with bit 9 clear is not a reference.
- R4: A timeout occurs on the `TIMEOUT_WORDS`-th word strobe after the last reference, or after the previous timeout, when no reference has arrived in between. On a timeout, `locked` falls in the next cycle and one slip is requested.
- R5: A slip withholds the word strobe at the next boundary. That word completes one bit later, so the gap between the two strobes is 21 bit strobes. Every other gap is 20.
- R6: `locked` rises in the cycle after the strobe of a reference flag word. It stays high until a timeout.
- R7: `line_pulse` is a one-cycle pulse in the cycle after the strobe of a reference flag word with H=1. A flag word with H=0 produces no pulse.
- R8: `frame_pulse` pulses together with `line_pulse` when that H=1 flag word has F=0 and the previous H=1 flag word had F=1. After reset, the previous F counts as 0.
- R9: A stream that starts at any bit offset d locks after exactly (d mod 20) slips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Serial data bit |
| ser_vld | input | 1 | Bit strobe: `ser_bit` is taken in this cycle |
| word_o | output | 20 | Parallel word, first-received bit in bit 0 |
| word_vld | output | 1 | One-cycle strobe for a new `word_o` |
| locked | output | 1 | Word boundary aligned to the timing reference |
| line_pulse | output | 1 | One pulse per line, on the end-of-active reference |
| frame_pulse | output | 1 | One pulse per frame, on the field-flag fall |

## Verification
The assertions check, on every cycle, the rules that hold between neighbouring signals:
- word strobes never come on consecutive cycles, and `word_o` is frozen between them;
- the timeout counter stays inside its range;
- `locked` falls only together with a slip request, and rises only after a word strobe;
- line pulses occur only while locked, and frame pulses only with a line pulse.

The bench scenarios cover the behaviour that depends on whole sequences:
- the exact number of slips a given bit offset needs, seen as 21-bit strobe gaps;
- the word count from the last reference to loss of lock;
- the count of line and frame pulses for a chosen pattern of field flags;
- rejection of a reference whose flag halves disagree;
- correct sample order in the words once aligned.

// File: rtl/swa_pkg.sv
package swa_pkg;
  localparam int SWA_WORD_W = 20;
  localparam int SWA_HALF_W = SWA_WORD_W / 2;

  typedef struct packed {
    logic f;
    logic h;
  } trs_mark_t;
endpackage

// File: rtl/swa_deser.sv
module swa_deser #(
  parameter int WORD_W = swa_pkg::SWA_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  input  logic              ser_vld,
  input  logic              slip_req,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shreg_nxt;
  logic [CNT_W-1:0]  bit_cnt;
  logic              slip_pend;
  logic              at_boundary;
  logic              take_slip;

  // newest bit enters at the top so the oldest ends at bit 0
  assign shreg_nxt   = {ser_bit, shreg[WORD_W-1:1]};
  assign at_boundary = ser_vld && (bit_cnt == LAST);
  assign take_slip   = at_boundary && slip_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      slip_pend <= 1'b0;
      word_o    <= '0;
      word_vld  <= 1'b0;
    end else begin
      word_vld  <= 1'b0;
      slip_pend <= slip_req | (slip_pend & ~take_slip);
      if (ser_vld) begin
        shreg <= shreg_nxt;
        if (bit_cnt == LAST) begin
          if (!slip_pend) begin
            word_o   <= shreg_nxt;
            word_vld <= 1'b1;
            bit_cnt  <= '0;
          end
          // on a slip the count holds at LAST: next bit closes the word
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swa_trs_detect.sv
module swa_trs_detect #(
  parameter int WORD_W = swa_pkg::SWA_WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  word_i,
  input  logic               word_vld,
  output logic               hit,
  output swa_pkg::trs_mark_t mark
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] half_eq;
  logic              is_ones;
  logic              is_zero;
  logic              is_flag;
  logic              seen_one;   // previous word all ones
  logic              seen_oz;    // ones then zero
  logic              seen_ozz;   // ones, zero, zero

  for (genvar b = 0; b < HALF_W; b++) begin : g_half_eq
    assign half_eq[b] = (word_i[b] == word_i[b + HALF_W]);
  end

  assign is_ones = &word_i;
  assign is_zero = ~|word_i;
  assign is_flag = (&half_eq) && word_i[HALF_W-1];
  assign hit     = word_vld && seen_ozz && is_flag;
  assign mark.f  = word_i[HALF_W-2];
  assign mark.h  = word_i[HALF_W-4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_one <= 1'b0;
      seen_oz  <= 1'b0;
      seen_ozz <= 1'b0;
    end else if (word_vld) begin
      seen_one <= is_ones;
      seen_oz  <= seen_one && is_zero;
      seen_ozz <= seen_oz && is_zero;
    end
  end
endmodule

// File: rtl/swa_lock_ctrl.sv
module swa_lock_ctrl #(
  parameter int TIMEOUT_WORDS = 2200,
  parameter int CNT_W         = $clog2(TIMEOUT_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_vld,
  input  logic             hit,
  output logic             locked,
  output logic             slip_req,
  output logic [CNT_W-1:0] wcnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt     <= '0;
      locked   <= 1'b0;
      slip_req <= 1'b0;
    end else begin
      slip_req <= 1'b0;
      if (word_vld) begin
        if (hit) begin
          wcnt   <= '0;
          locked <= 1'b1;
        end else if (wcnt == LAST) begin
          wcnt     <= '0;
          locked   <= 1'b0;
          slip_req <= 1'b1;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swa_marker.sv
module swa_marker (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  swa_pkg::trs_mark_t mark,
  output logic               line_pulse,
  output logic               frame_pulse
);
  logic last_f;
  logic eav;

  assign eav = hit && mark.h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_f      <= 1'b0;
      line_pulse  <= 1'b0;
      frame_pulse <= 1'b0;
    end else begin
      line_pulse  <= eav;
      frame_pulse <= eav && last_f && !mark.f;
      if (eav) last_f <= mark.f;
    end
  end
endmodule

// File: rtl/sync_word_aligner.sv
module sync_word_aligner #(
  parameter int WORD_W        = swa_pkg::SWA_WORD_W,
  parameter int TIMEOUT_WORDS = 2200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  input  logic              ser_vld,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld,
  output logic              locked,
  output logic              line_pulse,
  output logic              frame_pulse
);
  localparam int TCNT_W = $clog2(TIMEOUT_WORDS);

  logic               slip_req;
  logic               hit;
  swa_pkg::trs_mark_t mark;
  logic [TCNT_W-1:0]  wcnt;

  swa_deser #(.WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_vld(ser_vld),
    .slip_req(slip_req), .word_o(word_o), .word_vld(word_vld)
  );

  swa_trs_detect #(.WORD_W(WORD_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .word_i(word_o), .word_vld(word_vld),
    .hit(hit), .mark(mark)
  );

  swa_lock_ctrl #(.TIMEOUT_WORDS(TIMEOUT_WORDS), .CNT_W(TCNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .hit(hit),
    .locked(locked), .slip_req(slip_req), .wcnt(wcnt)
  );

  swa_marker u_marker (
    .clk(clk), .rst_n(rst_n), .hit(hit), .mark(mark),
    .line_pulse(line_pulse), .frame_pulse(frame_pulse)
  );
endmodule

// File: rtl/swa_checker.sv
module swa_checker #(
  parameter int WORD_W        = 20,
  parameter int TIMEOUT_WORDS = 2200,
  parameter int TCNT_W        = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld,
  input logic              locked,
  input logic              line_pulse,
  input logic              frame_pulse,
  input logic              slip_req,
  input logic [TCNT_W-1:0] wcnt
);
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
  a_r2_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word_o));
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wcnt) < TIMEOUT_WORDS);
  a_r4_unlock_with_slip: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> slip_req);
  a_r4_slip_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    slip_req |-> !locked);
  a_r5_slip_single: assert property (@(posedge clk) disable iff (!rst_n)
    slip_req |=> !slip_req);
  a_r6_lock_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(word_vld));
  a_r7_line_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |-> locked);
  a_r8_frame_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> line_pulse);
endmodule

bind sync_word_aligner swa_checker #(
  .WORD_W(WORD_W), .TIMEOUT_WORDS(TIMEOUT_WORDS), .TCNT_W(TCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_o(word_o), .word_vld(word_vld),
  .locked(locked), .line_pulse(line_pulse), .frame_pulse(frame_pulse),
  .slip_req(slip_req), .wcnt(wcnt)
);

// File: tb/sync_word_aligner_tb.sv
module sync_word_aligner_tb_top;
  localparam int T = 12;
  localparam logic [19:0] PAY = 20'h55555;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_bit = 1'b0;
  logic        ser_vld = 1'b0;
  logic [19:0] word_o;
  logic        word_vld, locked, line_pulse, frame_pulse;

  always #4 clk = ~clk;

  sync_word_aligner #(.WORD_W(20), .TIMEOUT_WORDS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_vld(ser_vld),
    .word_o(word_o), .word_vld(word_vld), .locked(locked),
    .line_pulse(line_pulse), .frame_pulse(frame_pulse)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // monitor state
  int n_line, n_frame, gap_min, gap_max, n_gap21, bits_since;
  int words_since, drop_cnt, bad_pay;
  bit have_strobe, prev_eav, prev_locked, h1, h2, h3;

  function automatic logic [19:0] flagw(bit f, bit h);
    logic [9:0] half;
    half = {1'b1, f, 1'b0, h, 6'b0};
    return {half, half};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_line = 0; n_frame = 0; gap_min = 1000; gap_max = 0; n_gap21 = 0;
    bits_since = 0; words_since = 0; drop_cnt = -1; bad_pay = 0;
    have_strobe = 0; prev_eav = 0; prev_locked = 0; h1 = 0; h2 = 0; h3 = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (line_pulse) n_line++;
      if (frame_pulse) n_frame++;
      if (word_vld) begin
        bit is_ref;
        if (have_strobe) begin
          if (bits_since < gap_min) gap_min = bits_since;
          if (bits_since > gap_max) gap_max = bits_since;
          if (bits_since == 21) n_gap21++;
        end
        have_strobe = 1;
        bits_since = 0;
        is_ref = h3 && (word_o[9:0] == word_o[19:10]) && word_o[9];
        words_since = is_ref ? 0 : words_since + 1;
        if (locked && prev_eav && word_o != PAY) bad_pay++;
        prev_eav = is_ref && word_o[6];
        h3 = h2 && (word_o == 20'h0);
        h2 = h1 && (word_o == 20'h0);
        h1 = (word_o == 20'hFFFFF);
      end
      if (ser_vld) bits_since++;
      if (prev_locked && !locked) drop_cnt = words_since;
      prev_locked = locked;
    end
  end

  task automatic send_bit(bit b);
    @(posedge clk); #2;
    ser_vld = 1'b1; ser_bit = b;
  endtask

  task automatic go_idle();
    @(posedge clk); #2;
    ser_vld = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic send_word(logic [19:0] w);
    for (int i = 0; i < 20; i++) send_bit(w[i]);
  endtask

  task automatic send_line(bit f, bit bad_flag);
    logic [19:0] fe, fs;
    fe = flagw(f, 1'b1);
    fs = flagw(f, 1'b0);
    if (bad_flag) begin fe[0] = 1'b1; fs[0] = 1'b1; end  // halves differ
    send_word(20'hFFFFF); send_word(20'h0); send_word(20'h0); send_word(fe);
    send_word(PAY); send_word(PAY);
    send_word(20'hFFFFF); send_word(20'h0); send_word(20'h0); send_word(fs);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ser_vld = 1'b0; ser_bit = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    clear_mon();
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(!word_vld && !locked && !line_pulse && !frame_pulse, "R1 flags",
          {word_vld, locked, line_pulse, frame_pulse}, 0);
    check(word_o == 20'h0, "R1 word", int'(word_o), 0);
  endtask

  task automatic t_aligned();
    bit fs[7] = '{0, 1, 1, 0, 0, 1, 0};
    do_reset();
    foreach (fs[i]) send_line(fs[i], 1'b0);
    go_idle();
    check(locked, "R6 locked after reference", locked, 1);
    check(n_line == 7, "R7 one pulse per line, none on H=0", n_line, 7);
    check(n_frame == 2, "R8 frame on F 1->0", n_frame, 2);
    check(gap_min == 20 && gap_max == 20, "R2 strobe every 20 bits", gap_max, 20);
    check(bad_pay == 0, "R2 bit order in word", bad_pay, 0);
  endtask

  task automatic t_near_miss();
    do_reset();
    for (int i = 0; i < 3; i++) send_line(1'b1, 1'b1);
    go_idle();
    check(!locked, "R3 unequal halves rejected", locked, 0);
    check(n_line == 0, "R3 no line pulse on bad flag", n_line, 0);
  endtask

  task automatic t_misaligned();
    int lines = 0;
    do_reset();
    for (int i = 0; i < 7; i++) send_bit(i[0]);
    while (!locked && lines < 40) begin
      send_line(1'b1, 1'b0);
      lines++;
    end
    check(locked, "R9 lock reached from offset 7", locked, 1);
    check(n_gap21 == 7, "R9 slip count equals offset", n_gap21, 7);
    check(gap_max == 21 && gap_min == 20, "R5 slip gap 21 bits", gap_max, 21);
    n_line = 0; bad_pay = 0;
    for (int i = 0; i < 3; i++) send_line(1'b1, 1'b0);
    go_idle();
    check(n_line == 3, "R7 line pulses after alignment", n_line, 3);
    check(bad_pay == 0, "R2 words aligned after slips", bad_pay, 0);
  endtask

  task automatic t_loss();
    do_reset();
    send_line(1'b0, 1'b0); send_line(1'b0, 1'b0);
    check(locked, "R6 lock before loss", locked, 1);
    for (int i = 0; i < (T + 4) * 20; i++) send_bit(i[0]);
    go_idle();
    check(!locked, "R4 unlocked after timeout", locked, 0);
    check(drop_cnt == T, "R4 words to loss", drop_cnt, T);
    check(n_gap21 == 1, "R5 one slip after timeout", n_gap21, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_mon();
    t_reset();
    t_aligned();
    t_near_miss();
    t_misaligned();
    t_loss();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule